// File: doc/BRIEF.md
# Two-Bank Drum Pattern Store with Layered Playback

This block holds the rhythm program of a drum machine as one-byte events in two equal banks. Each bank stores 256 events laid out as four sections of 64: two main scores and two bridges. One address goes to both banks. Each bank has its own active-low enable, so a pattern can be entered into one bank while the other is left untouched.

On playback the sequencer steps the address and the block returns the selected event one clock later. If both banks are enabled, the bytes at that address in the two banks are merged by a bitwise OR. The same section of each bank therefore sounds at once, which layers two drum parts into one track. A byte of zero is a rest, so a rest in one bank lets the other bank's hit through unchanged.

Top module: `banked_pattern_store`

## Requirements
- R1: After reset every event in both banks is zero (a rest) and `rd_data` is zero.
- R2: `addr[7:6]` picks the section (00 first score, 01 second score, 10 first bridge, 11 second bridge) and `addr[5:0]` picks the event within it; all 256 addresses of a bank are distinct locations.
- R3: `bank_en_n[i]` low enables bank i; a clock edge with `wr_en` high stores `wr_data` at `addr` in each enabled bank.
- R4: A bank whose `bank_en_n` bit is high is not changed by a write.
- R5: `rd_data` is registered: one clock after `addr` and `bank_en_n` are presented it equals the bitwise OR of the bytes at `addr` in all enabled banks.
- R6: With both `bank_en_n` bits high, `rd_data` is zero one clock later.
- R7: A write with both banks enabled stores the same byte into both banks.
- R8: In a write cycle `rd_data` reports the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Section (bits 7:6) and event (bits 5:0) |
| wr_data | input | 8 | Event byte to store |
| wr_en | input | 1 | Write strobe |
| bank_en_n | input | 2 | Per-bank enable, active low, bit i for bank i |
| rd_data | output | 8 | Merged event byte of the enabled banks |

## Verification
Reads are tried with each enable pattern at the same address holding different bytes per bank: one bank alone tells the banks apart, both together shows the OR merge, none shows the idle zero. Writes are tried with one bank, both banks and no bank enabled, and read back per bank, which separates a correct per-bank write gate from one that writes everywhere or nowhere. Neighbouring addresses across a section boundary and a whole section filled in both banks with different patterns check addressing and layered playback, and a write to a location that is read in the same cycle checks that old contents come out.

// File: rtl/banked_pattern_store.sv
module banked_pattern_store #(
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 8,
  parameter int BANKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [EVT_W-1:0]  wr_data,
  input  logic              wr_en,
  input  logic [BANKS-1:0]  bank_en_n,
  output logic [EVT_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [EVT_W-1:0] bank_byte [BANKS];
  logic [EVT_W-1:0] merged;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [EVT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en && !bank_en_n[b]) begin
        mem[addr] <= wr_data;
      end
    end

    assign bank_byte[b] = bank_en_n[b] ? '0 : mem[addr];
  end

  always_comb begin
    merged = '0;
    for (int b = 0; b < BANKS; b++) merged = merged | bank_byte[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= merged;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> rd_data == '0);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_en_n) |=> rd_data == '0);

  // R3
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(bank_en_n) == 2'b10 &&
     !wr_en && bank_en_n == 2'b10 && addr == $past(addr))
    |=> rd_data == $past(wr_data, 2));

  // R5
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && addr == $past(addr) && bank_en_n == $past(bank_en_n) &&
     !$past(wr_en))
    |=> $stable(rd_data));
endmodule

// File: tb/test_banked_pattern_store.sv
module test_banked_pattern_store;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic [1:0] bank_en_n = 2'b11;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] model [2][256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         chk_q [$];

  banked_pattern_store i_banked_pattern_store (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .bank_en_n(bank_en_n), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [7:0] d, input bit we,
                      input logic [1:0] en, input string tag, input bit chk);
    logic [7:0] exp;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = we; bank_en_n = en;
    exp = '0;
    for (int b = 0; b < 2; b++) if (!en[b]) exp = exp | model[b][a];
    exp_q.push_back(exp); tag_q.push_back(tag); chk_q.push_back(chk);
    if (we) for (int b = 0; b < 2; b++) if (!en[b]) model[b][a] = d;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      bit c;
      e = exp_q.pop_front(); t = tag_q.pop_front(); c = chk_q.pop_front();
      if (c) check(t, rd_data, e);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 256; i++) model[b][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", rd_data, 8'h00);

    // R1: every location reads as rest after reset
    step(8'h00, 8'h00, 0, 2'b00, "R1 rest at 00", 1);
    step(8'hFF, 8'h00, 0, 2'b00, "R1 rest at FF", 1);
    step(8'h77, 8'h00, 0, 2'b10, "R1 rest bank0", 1);

    // R3/R4: write each bank alone
    step(8'h05, 8'h11, 1, 2'b10, "R3 write bank0", 0);
    step(8'h05, 8'h22, 1, 2'b01, "R4 write bank1 only", 0);
    step(8'h05, 8'h00, 0, 2'b10, "R4 bank0 kept", 1);
    step(8'h05, 8'h00, 0, 2'b01, "R3 bank1 readback", 1);
    // R5: merge
    step(8'h05, 8'h00, 0, 2'b00, "R5 merged read", 1);
    // R6: nothing enabled
    step(8'h05, 8'h00, 0, 2'b11, "R6 idle zero", 1);
    // R4: write with no bank enabled is dropped
    step(8'h10, 8'hFF, 1, 2'b11, "R4 disabled write", 1);
    step(8'h10, 8'h00, 0, 2'b00, "R4 nothing stored", 1);
    // R7: write both
    step(8'h80, 8'h5A, 1, 2'b00, "R7 write both", 0);
    step(8'h80, 8'h00, 0, 2'b10, "R7 bank0 copy", 1);
    step(8'h80, 8'h00, 0, 2'b01, "R7 bank1 copy", 1);
    // R2: section boundary
    step(8'h3F, 8'hA1, 1, 2'b10, "R2 write 3F", 0);
    step(8'h40, 8'hB2, 1, 2'b10, "R2 write 40", 0);
    step(8'h3F, 8'h00, 0, 2'b10, "R2 read 3F", 1);
    step(8'h40, 8'h00, 0, 2'b10, "R2 read 40", 1);
    step(8'hBF, 8'h00, 0, 2'b10, "R2 bridge alias clear", 1);
    // R8: read during write
    step(8'h05, 8'h44, 1, 2'b10, "R8 old value out", 1);
    step(8'h05, 8'h00, 0, 2'b10, "R8 new value after", 1);

    // R2/R5: second bridge section layered across banks
    for (int i = 0; i < 64; i++) step(8'hC0 + 8'(i), 8'(i), 1, 2'b10, "R3 fill", 0);
    for (int i = 0; i < 64; i++) step(8'hC0 + 8'(i), 8'(i << 2), 1, 2'b01, "R4 fill", 0);
    for (int i = 0; i < 64; i++) step(8'hC0 + 8'(i), 8'h00, 0, 2'b00, "R5 layered section", 1);
    for (int i = 0; i < 8; i++) step(8'hC0 + 8'(i), 8'h00, 0, 2'b01, "R4 bank1 section", 1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule